// File: doc/BRIEF.md
# NOR Flash Sector Range Eraser

This block erases a contiguous range of sectors in a parallel NOR flash bank. The host names the first and the last sector index, supplies a protect bit for each sector and a table with the base word address of each sector, chooses one of two command families and pulses `start`. The block walks the range in ascending order. It skips any sector whose protect bit is set and counts it. It erases every other sector with the command sequence of the chosen family, waits a fixed settle time, then polls the sector until the device reports completion or a timeout expires.

One command family drives the device through a status register and writes every command at the sector address. The other opens each command with a two-write unlock handshake at fixed offsets from the bank base, which is entry 0 of the address table. Every command byte is copied into the low byte of each device lane of the data bus, so that several devices placed side by side receive the same command in one write. A sector is finished only when every lane reports ready. A timeout ends the whole range at once and returns the bank to read mode. `busy` covers the whole operation. A one-cycle `done` pulse then carries the pass or fail result and the skip count.

Top module: `nor_range_eraser`

## Requirements
- R1: A request whose first index is negative, whose first index exceeds the last, or whose last index is NSECT or more is refused. In the cycle after `start`, `done` is high with `pass`=0 and `skipped`=0, and no bus cycle is issued.
- R2: A sector in the range whose `protect` bit is set gets no bus cycle. `skipped` reports the number of set protect bits between the first and the last index, inclusive, whether the run passes or fails.
- R3: Sectors are visited in ascending index order. Each visit, protected or not, starts with one bus-idle selection cycle, and one more idle cycle follows the last visit.
- R4: With `family`=0, a sector erase is three consecutive writes to the sector address with data bytes 0x50, 0x20 and 0xD0. Each byte is placed zero-extended in every LANE_W-bit lane.
- R5: With `family`=1, a sector erase is six consecutive writes: 0xAA at bank+0x555, 0x55 at bank+0x2AA, 0x80 at bank+0x555, 0xAA at bank+0x555, 0x55 at bank+0x2AA, then 0x30 at the sector address. Here bank is table entry 0, and the bytes are replicated per lane as in R4.
- R6: After the last erase write the bus stays idle for exactly SETTLE_CYC cycles. Then one read of the sector address is issued in every cycle.
- R7: A poll read completes the sector only when bit 7 of every lane of `fl_rdata` is set. A word with bit 7 set in only some lanes counts as not ready.
- R8: Once a sector completes, one read-mode write goes to the bank base before the next selection cycle: 0xFF per lane for family 0, 0xF0 per lane for family 1.
- R9: If TMO_CYC poll reads pass without completion, family 0 writes 0xB0 per lane at the sector address and then writes read mode. Family 1 only writes read mode. Then `done` rises with `pass`=0 and no later sector is touched.
- R10: `busy` is high from the cycle after an accepted `start` up to and including the single `done` cycle. `pass`=1 when every unprotected sector completed. `start` is ignored while `busy` is high, and with `busy` low the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| family | input | 1 | Command family: 0 status-register, 1 unlock-handshake |
| first_idx | input | IW | First sector index, signed |
| last_idx | input | IW | Last sector index, signed |
| protect | input | NSECT | Per-sector skip bits |
| sect_base | input | NSECT*AW | Sector base word addresses, entry i at bits [i*AW +: AW] |
| busy | output | 1 | Range operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last operation, valid at done |
| skipped | output | CNTW | Protected sectors in the last range |
| fl_wr | output | 1 | Flash write strobe, one word per cycle |
| fl_rd | output | 1 | Flash read strobe, data taken in the same cycle |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |

## Verification
The assertions assume that `family`, `protect` and `sect_base` hold still for as long as `busy` is high, and one property flags any change. The bench sets these inputs only between operations, while the block is idle. The one `start` pulse it issues during an operation carries the same inputs. The flash model answers a poll combinationally in the read cycle and counts reads from the last erase-confirm write. Each sector gets its own ready latency, and some sectors answer only in one lane. This lets the bench hit completion on the first read, completion on the very last allowed read, a timeout, and a lane-partial status.

// File: rtl/nor_erase_pkg.sv
`timescale 1ns/1ps
package nor_erase_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_CMD, ST_SETTLE, ST_POLL, ST_RDM, ST_SUSP, ST_RST, ST_FIN
  } nor_state_e;

  typedef enum logic [1:0] {
    OP_ERASE, OP_READ_MODE, OP_SUSPEND
  } nor_op_e;

  localparam logic FAM_STATUS = 1'b0;
  localparam logic FAM_UNLOCK = 1'b1;
endpackage

// File: rtl/nor_cmd_gen.sv
`timescale 1ns/1ps
module nor_cmd_gen import nor_erase_pkg::*; #(
  parameter int AW     = 16,
  parameter int LANES  = 2,
  parameter int LANE_W = 16,
  localparam int DW    = LANES * LANE_W
) (
  input  logic          fam,
  input  nor_op_e       op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] sect_addr,
  input  logic [AW-1:0] bank_addr,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic          last_step
);
  function automatic logic [DW-1:0] lane_rep(input logic [7:0] b);
    logic [DW-1:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++) r[l*LANE_W +: LANE_W] = LANE_W'(b);
    return r;
  endfunction

  localparam logic [AW-1:0] OFS_A = AW'(12'h555);
  localparam logic [AW-1:0] OFS_B = AW'(12'h2AA);

  logic [7:0] cbyte;

  always_comb begin
    addr  = sect_addr;
    cbyte = 8'h00;
    unique case (op)
      OP_READ_MODE: begin
        addr  = bank_addr;
        cbyte = (fam == FAM_UNLOCK) ? 8'hF0 : 8'hFF;
      end
      OP_SUSPEND: cbyte = 8'hB0;
      default: begin
        if (fam == FAM_STATUS) begin
          case (step)
            3'd0:    cbyte = 8'h50;
            3'd1:    cbyte = 8'h20;
            default: cbyte = 8'hD0;
          endcase
        end else begin
          case (step)
            3'd0, 3'd3: begin addr = bank_addr + OFS_A; cbyte = 8'hAA; end
            3'd1, 3'd4: begin addr = bank_addr + OFS_B; cbyte = 8'h55; end
            3'd2:       begin addr = bank_addr + OFS_A; cbyte = 8'h80; end
            default:    cbyte = 8'h30;
          endcase
        end
      end
    endcase
  end

  assign data      = lane_rep(cbyte);
  assign last_step = (fam == FAM_UNLOCK) ? (step == 3'd5) : (step == 3'd2);
endmodule

// File: rtl/nor_wait_timer.sv
`timescale 1ns/1ps
module nor_wait_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          hit
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == limit - 1'b1);
endmodule

// File: rtl/nor_prot_count.sv
`timescale 1ns/1ps
module nor_prot_count #(
  parameter int NSECT  = 8,
  localparam int IW    = $clog2(NSECT) + 1,
  localparam int CNTW  = $clog2(NSECT + 1)
) (
  input  logic [NSECT-1:0]     mask,
  input  logic signed [IW-1:0] first_i,
  input  logic signed [IW-1:0] last_i,
  output logic [CNTW-1:0]      count
);
  logic [NSECT-1:0] sel;

  for (genvar g = 0; g < NSECT; g++) begin : g_sel
    assign sel[g] = mask[g] && (int'(first_i) <= g) && (g <= int'(last_i));
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NSECT; i++) count = count + CNTW'(sel[i]);
  end
endmodule

// File: rtl/nor_range_eraser.sv
`timescale 1ns/1ps
module nor_range_eraser import nor_erase_pkg::*; #(
  parameter int NSECT      = 8,
  parameter int AW         = 16,
  parameter int LANES      = 2,
  parameter int LANE_W     = 16,
  parameter int SETTLE_CYC = 10,
  parameter int TMO_CYC    = 20,
  localparam int DW   = LANES * LANE_W,
  localparam int IW   = $clog2(NSECT) + 1,
  localparam int CNTW = $clog2(NSECT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   family,
  input  logic signed [IW-1:0]   first_idx,
  input  logic signed [IW-1:0]   last_idx,
  input  logic [NSECT-1:0]       protect,
  input  logic [NSECT*AW-1:0]    sect_base,
  output logic                   busy,
  output logic                   done,
  output logic                   pass,
  output logic [CNTW-1:0]        skipped,
  output logic                   fl_wr,
  output logic                   fl_rd,
  output logic [AW-1:0]          fl_addr,
  output logic [DW-1:0]          fl_wdata,
  input  logic [DW-1:0]          fl_rdata
);
  localparam int SW   = $clog2(NSECT);
  localparam int TMAX = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  function automatic logic lanes_ready(input logic [DW-1:0] w);
    logic r;
    r = 1'b1;
    for (int l = 0; l < LANES; l++) r &= w[l*LANE_W + 7];
    return r;
  endfunction

  function automatic logic bad_request(input logic signed [IW-1:0] f,
                                       input logic signed [IW-1:0] l);
    return f[IW-1] || (f > l) || (int'(l) >= NSECT);
  endfunction

  nor_state_e      st;
  logic [IW-1:0]   cur, last_r;
  logic [2:0]      step;
  logic            pass_r;
  logic [CNTW-1:0] skip_r, prot_cnt;
  logic [SW-1:0]   cur_sect;
  logic [AW-1:0]   sect_addr, gen_addr;
  logic [DW-1:0]   gen_data;
  logic            cmd_last, tmr_hit, tmr_clr, rd_ready;
  logic [TW-1:0]   tmr_limit;
  nor_op_e         op;

  // named events used by the bound checker
  logic ev_launch, ev_pass, ev_expire, ev_skip;

  assign cur_sect  = cur[SW-1:0];
  assign sect_addr = sect_base[cur_sect*AW +: AW];
  assign rd_ready  = lanes_ready(fl_rdata);

  assign ev_launch = (st == ST_CMD) && cmd_last;
  assign ev_pass   = (st == ST_POLL) && rd_ready;
  assign ev_expire = (st == ST_POLL) && !rd_ready && tmr_hit;
  assign ev_skip   = (st == ST_SEL) && (cur <= last_r) && protect[cur_sect];

  nor_prot_count #(.NSECT(NSECT)) u_cnt (
    .mask(protect), .first_i(first_idx), .last_i(last_idx), .count(prot_cnt)
  );

  assign tmr_limit = (st == ST_SETTLE) ? TW'(SETTLE_CYC) : TW'(TMO_CYC);
  assign tmr_clr   = !((st == ST_SETTLE) || (st == ST_POLL)) ||
                     ((st == ST_SETTLE) && tmr_hit);

  nor_wait_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(tmr_limit), .hit(tmr_hit)
  );

  always_comb begin
    case (st)
      ST_CMD:  op = OP_ERASE;
      ST_SUSP: op = OP_SUSPEND;
      default: op = OP_READ_MODE;
    endcase
  end

  nor_cmd_gen #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_gen (
    .fam(family), .op(op), .step(step), .sect_addr(sect_addr),
    .bank_addr(sect_base[AW-1:0]), .addr(gen_addr), .data(gen_data),
    .last_step(cmd_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cur    <= '0;
      last_r <= '0;
      step   <= '0;
      pass_r <= 1'b0;
      skip_r <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          if (bad_request(first_idx, last_idx)) begin
            pass_r <= 1'b0;
            skip_r <= '0;
            st     <= ST_FIN;
          end else begin
            cur    <= $unsigned(first_idx);
            last_r <= $unsigned(last_idx);
            skip_r <= prot_cnt;
            st     <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (cur > last_r) begin
            pass_r <= 1'b1;
            st     <= ST_FIN;
          end else if (protect[cur_sect]) begin
            cur <= cur + 1'b1;
          end else begin
            step <= '0;
            st   <= ST_CMD;
          end
        end
        ST_CMD:    if (cmd_last) st <= ST_SETTLE; else step <= step + 1'b1;
        ST_SETTLE: if (tmr_hit) st <= ST_POLL;
        ST_POLL: begin
          if (rd_ready)     st <= ST_RDM;
          else if (tmr_hit) st <= (family == FAM_STATUS) ? ST_SUSP : ST_RST;
        end
        ST_RDM: begin
          cur <= cur + 1'b1;
          st  <= ST_SEL;
        end
        ST_SUSP: st <= ST_RST;
        ST_RST: begin
          pass_r <= 1'b0;
          st     <= ST_FIN;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_FIN);
  assign pass     = pass_r;
  assign skipped  = skip_r;
  assign fl_wr    = (st == ST_CMD) || (st == ST_RDM) || (st == ST_SUSP) || (st == ST_RST);
  assign fl_rd    = (st == ST_POLL);
  assign fl_addr  = fl_rd ? sect_addr : (fl_wr ? gen_addr : '0);
  assign fl_wdata = fl_wr ? gen_data : '0;
endmodule

// File: rtl/nor_erase_checker.sv
`timescale 1ns/1ps
module nor_erase_checker #(
  parameter int NSECT      = 8,
  parameter int AW         = 16,
  parameter int LANES      = 2,
  parameter int LANE_W     = 16,
  parameter int SETTLE_CYC = 10,
  localparam int DW  = LANES * LANE_W,
  localparam int IW  = $clog2(NSECT) + 1,
  localparam int QW  = $clog2(SETTLE_CYC + 2) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 family,
  input logic signed [IW-1:0] first_idx,
  input logic signed [IW-1:0] last_idx,
  input logic [NSECT-1:0]     protect,
  input logic [NSECT*AW-1:0]  sect_base,
  input logic                 busy,
  input logic                 done,
  input logic                 pass,
  input logic                 fl_wr,
  input logic                 fl_rd,
  input logic [AW-1:0]        fl_addr,
  input logic [DW-1:0]        fl_wdata,
  input logic [DW-1:0]        fl_rdata,
  input logic                 ev_launch,
  input logic                 ev_pass,
  input logic                 ev_expire,
  input logic                 ev_skip
);
  function automatic logic [DW-1:0] rep(input logic [7:0] b);
    logic [DW-1:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++) r[l*LANE_W +: LANE_W] = {{(LANE_W-8){1'b0}}, b};
    return r;
  endfunction

  function automatic logic all_set(input logic [DW-1:0] w);
    logic r;
    r = 1'b1;
    for (int l = 0; l < LANES; l++) r = r && w[l*LANE_W + 7];
    return r;
  endfunction

  logic bad_req;
  assign bad_req = (first_idx < 0) || (first_idx > last_idx) || (int'(last_idx) >= NSECT);

  // idle cycles since the last write, saturating
  logic [QW-1:0] quiet;
  logic          rd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet <= '0;
      rd_q  <= 1'b0;
    end else begin
      rd_q <= fl_rd;
      if (fl_wr) quiet <= '0;
      else if (!fl_rd && quiet != {QW{1'b1}}) quiet <= quiet + 1'b1;
    end
  end

  assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && bad_req) |=> (done && !pass));

  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> (!fl_wr && !fl_rd));

  assert_hold_inputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(protect) && $stable(sect_base) && $stable(family)));

  assert_settle_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && !rd_q) |-> (quiet == QW'(SETTLE_CYC)));

  assert_launch_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> (!fl_wr && !fl_rd));

  assert_partial_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && !all_set(fl_rdata)) |-> !ev_pass);

  assert_read_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass |=> (fl_wr && fl_addr == sect_base[AW-1:0] &&
                 fl_wdata == rep(family ? 8'hF0 : 8'hFF)));

  assert_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_expire && !family) |=> (fl_wr && fl_wdata == rep(8'hB0)));

  assert_unlock_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_expire && family) |=> (fl_wr && fl_wdata == rep(8'hF0)));

  assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_wr && !fl_rd));
endmodule

bind nor_range_eraser nor_erase_checker #(
  .NSECT(NSECT), .AW(AW), .LANES(LANES), .LANE_W(LANE_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .family(family),
  .first_idx(first_idx), .last_idx(last_idx), .protect(protect),
  .sect_base(sect_base), .busy(busy), .done(done), .pass(pass),
  .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
  .fl_rdata(fl_rdata), .ev_launch(ev_launch), .ev_pass(ev_pass),
  .ev_expire(ev_expire), .ev_skip(ev_skip)
);

// File: tb/sim_nor_range_eraser.sv
`timescale 1ns/1ps
module sim_nor_range_eraser;
  localparam int NS = 8;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int S  = 10;
  localparam int T  = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, start, family;
  logic signed [3:0] first_idx, last_idx;
  logic [NS-1:0]     protect;
  logic [NS*AW-1:0]  sect_base;
  logic              busy, done, pass, fl_wr, fl_rd;
  logic [3:0]        skipped;
  logic [AW-1:0]     fl_addr;
  logic [DW-1:0]     fl_wdata, fl_rdata;

  nor_range_eraser u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .family(family),
    .first_idx(first_idx), .last_idx(last_idx), .protect(protect),
    .sect_base(sect_base), .busy(busy), .done(done), .pass(pass),
    .skipped(skipped), .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [31:0] rep(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  function automatic logic [15:0] tab(input int s);
    return 16'h1000 + 16'(s) * 16'h0800;
  endfunction

  // flash model: per-sector ready latency in reads, optional one-lane status
  int   need_arr [NS];
  bit   part_arr [NS];
  bit   fm_act = 1'b0;
  bit   fm_part = 1'b0;
  int   fm_need = 1;
  int   fm_rc = 0;

  always @(posedge clk) begin
    if (fl_wr && (fl_wdata == rep(8'hD0) || fl_wdata == rep(8'h30))) begin
      for (int k = 0; k < NS; k++) begin
        if (tab(k) == fl_addr) begin
          fm_act  <= 1'b1;
          fm_need <= need_arr[k];
          fm_part <= part_arr[k];
          fm_rc   <= 0;
        end
      end
    end else if (fl_rd) begin
      fm_rc <= fm_rc + 1;
    end
  end

  assign fl_rdata = !fm_act ? 32'h0 :
                    fm_part ? 32'h0000_0080 :
                    ((fm_rc + 1 >= fm_need) ? 32'h0080_0080 : 32'h0040_0000);

  // reference timeline: one entry per clock
  typedef struct packed {
    logic        busy, done, wr, rd;
    logic [15:0] addr;
    logic [31:0] data;
    logic        res, ok;
    logic [3:0]  skip;
  } exp_t;

  exp_t  q[$];
  string tq[$];

  task automatic push(input logic b, input logic d, input logic w, input logic r,
                      input logic [15:0] a, input logic [31:0] dt, input string tag);
    exp_t e;
    e = '{busy:b, done:d, wr:w, rd:r, addr:a, data:dt, res:1'b0, ok:1'b0, skip:4'd0};
    q.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic push_fin(input logic okv, input int sk, input string tag);
    exp_t e;
    e = '{busy:1'b1, done:1'b1, wr:1'b0, rd:1'b0, addr:16'h0, data:32'h0,
          res:1'b1, ok:okv, skip:4'(sk)};
    q.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic build(input bit fam, input int first, input int last, input logic [NS-1:0] m);
    int  sk;
    bit  abort, good;
    int  n;
    logic [15:0] b, sa;
    b = tab(0);
    if (first < 0 || first > last || last >= NS) begin
      push_fin(1'b0, 0, "R1");
    end else begin
      sk = 0;
      for (int s = first; s <= last; s++) if (m[s]) sk++;
      abort = 1'b0;
      for (int s = first; s <= last && !abort; s++) begin
        push(1, 0, 0, 0, 16'h0, 32'h0, "R3");
        if (m[s]) continue;
        sa = tab(s);
        if (!fam) begin
          push(1, 0, 1, 0, sa, rep(8'h50), "R4");
          push(1, 0, 1, 0, sa, rep(8'h20), "R4");
          push(1, 0, 1, 0, sa, rep(8'hD0), "R4");
        end else begin
          push(1, 0, 1, 0, b + 16'h555, rep(8'hAA), "R5");
          push(1, 0, 1, 0, b + 16'h2AA, rep(8'h55), "R5");
          push(1, 0, 1, 0, b + 16'h555, rep(8'h80), "R5");
          push(1, 0, 1, 0, b + 16'h555, rep(8'hAA), "R5");
          push(1, 0, 1, 0, b + 16'h2AA, rep(8'h55), "R5");
          push(1, 0, 1, 0, sa, rep(8'h30), "R5");
        end
        for (int i = 0; i < S; i++) push(1, 0, 0, 0, 16'h0, 32'h0, "R6");
        good = !part_arr[s] && need_arr[s] <= T;
        n = good ? need_arr[s] : T;
        for (int i = 0; i < n; i++) push(1, 0, 0, 1, sa, 32'h0, "R7");
        if (good) begin
          push(1, 0, 1, 0, b, rep(fam ? 8'hF0 : 8'hFF), "R8");
        end else begin
          if (!fam) push(1, 0, 1, 0, sa, rep(8'hB0), "R9");
          push(1, 0, 1, 0, b, rep(fam ? 8'hF0 : 8'hFF), "R9");
          push_fin(1'b0, sk, "R9");
          abort = 1'b1;
        end
      end
      if (!abort) begin
        push(1, 0, 0, 0, 16'h0, 32'h0, "R3");
        push_fin(1'b1, sk, "R10");
      end
    end
    push(0, 0, 0, 0, 16'h0, 32'h0, "R10");
  endtask

  task automatic compare(input exp_t e, input string tag);
    logic good;
    good = (busy === e.busy) && (done === e.done) && (fl_wr === e.wr) && (fl_rd === e.rd);
    if (e.wr || e.rd) good = good && (fl_addr === e.addr);
    if (e.wr) good = good && (fl_wdata === e.data);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual busy=%0b done=%0b wr=%0b rd=%0b addr=%h data=%h expected busy=%0b done=%0b wr=%0b rd=%0b addr=%h data=%h",
               tag, busy, done, fl_wr, fl_rd, fl_addr, fl_wdata,
               e.busy, e.done, e.wr, e.rd, e.addr, e.data);
    end
    if (e.res) begin
      checks++;
      if (pass !== e.ok) begin
        errors++;
        $display("FAIL %s: pass actual=%0b expected=%0b", tag, pass, e.ok);
      end
      checks++;
      if (skipped !== e.skip) begin
        errors++;
        $display("FAIL R2: skipped actual=%0d expected=%0d", skipped, e.skip);
      end
    end
  endtask

  task automatic run_op(input bit fam, input int first, input int last,
                        input logic [NS-1:0] m, input bit mid_pulse);
    int idx;
    family    = fam;
    first_idx = 4'(first);
    last_idx  = 4'(last);
    protect   = m;
    build(fam, first, last, m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0;
    while (q.size() > 0) begin
      compare(q.pop_front(), tq.pop_front());
      if (mid_pulse && idx == 2) start = 1'b1;   // R10: ignored while busy
      else start = 1'b0;
      idx++;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10: watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; family = 1'b0;
    first_idx = 4'sd0; last_idx = 4'sd0; protect = '0;
    for (int i = 0; i < NS; i++) begin
      sect_base[i*AW +: AW] = tab(i);
      need_arr[i] = 2;
      part_arr[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || fl_wr !== 1'b0 || fl_rd !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset actual busy=%0b done=%0b wr=%0b rd=%0b expected all 0",
               busy, done, fl_wr, fl_rd);
    end

    // R4 R6 R7 R8 R10: status family, varied latencies, start pulse while busy
    need_arr[0] = 3; need_arr[1] = 1; need_arr[2] = 5;
    run_op(1'b0, 0, 2, 8'h00, 1'b1);

    // R5 R2: unlock family with protected sectors 2 and 4
    for (int i = 0; i < NS; i++) need_arr[i] = 2;
    run_op(1'b1, 1, 4, 8'b0001_0100, 1'b0);

    // R1: negative first, first beyond last
    run_op(1'b0, -1, 3, 8'h00, 1'b0);
    run_op(1'b1, 5, 3, 8'h00, 1'b0);

    // R9: status family timeout on sector 1 aborts the range
    need_arr[0] = 4; need_arr[1] = 99;
    run_op(1'b0, 0, 3, 8'b0000_1000, 1'b0);

    // R7 R9: unlock family, sector 3 answers in one lane only
    for (int i = 0; i < NS; i++) need_arr[i] = 2;
    part_arr[3] = 1'b1;
    run_op(1'b1, 3, 5, 8'h00, 1'b0);
    part_arr[3] = 1'b0;

    // R2: whole range protected
    run_op(1'b0, 0, 7, 8'hFF, 1'b0);

    // R9 boundary: ready on the last allowed read, then one read too late
    need_arr[7] = T;
    run_op(1'b0, 7, 7, 8'h00, 1'b0);
    need_arr[6] = T + 1;
    run_op(1'b0, 6, 6, 8'h00, 1'b0);

    // R3 R5: single sector, unlock family, first equals last
    need_arr[0] = 1;
    run_op(1'b1, 0, 0, 8'hFE, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule